// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Pair

This block brings two clocks down to a shared phase-comparison rate for a frequency synthesizer. The feedback path is a pulse-swallow counter. It runs on the output clock of an external 16/17 dual-modulus prescaler and drives that prescaler's modulus-control input. The reference path is a plain programmable divider that runs on the reference clock. Each path emits a one-cycle pulse at its terminal count. A phase detector downstream compares the two pulses.

Two ratio sets are held at the inputs, and each set has a feedback word and a reference word. A single select pin picks the set in use. The feedback word is a 14-bit value: bits [13:4] are the main count P and bits [3:0] are the swallow count A. The overall VCO-to-pulse ratio is 16·P + A, which is numerically equal to the word itself. Typical programmed values are 10519 and 4269 for the feedback words and 492 for both reference words.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status level, or a pulse. The select and ratio inputs are sampled only at terminal count. They must be held steady for at least one cycle of each clock around any change.

Top module: `dual_mod_div_pair`

## Requirements
- R1: The feedback pulse repeats every 16·P + A VCO cycles, where P is `fb_word[13:4]` and A is `fb_word[3:0]`.
- R2: In each feedback period, `mod_ctl` is 1 (requesting divide-by-17) for the first A prescaler cycles and 0 for the remaining P − A cycles. When A = 0 it stays 0 for the whole period.
- R3: `fb_pulse` is high for exactly one prescaler cycle per feedback period.
- R4: `ref_pulse` is high for exactly one reference cycle, once every R reference cycles, where R is the selected 11-bit reference word.
- R5: `bank_sel` = 1 uses `fb_word_a`/`ref_word_a`, and `bank_sel` = 0 uses `fb_word_b`/`ref_word_b`.
- R6: A change of `bank_sel` or of a ratio word never alters a period already in progress. The period that follows the next terminal count uses the new value.
- R7: While `rst` (synchronous, active high) is asserted, both pulses are 0 and both counters hold the load values of the selected set. After release, the first `fb_pulse` follows the P-th prescaler edge and the first `ref_pulse` follows the R-th reference edge.
- R8: A feedback word below 256 is treated as 256 (P = 16, A = 0).
- R9: A reference word below 2 is treated as 2.
- R10: The largest words, 16383 for feedback and 2047 for reference, divide by exactly those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock (feedback domain) |
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high, seen in both domains |
| bank_sel | input | 1 | Ratio set select: 1 = set A, 0 = set B |
| fb_word_a | input | 14 | Feedback word of set A, {P[9:0], A[3:0]} |
| fb_word_b | input | 14 | Feedback word of set B, {P[9:0], A[3:0]} |
| ref_word_a | input | 11 | Reference ratio of set A |
| ref_word_b | input | 11 | Reference ratio of set B |
| fb_pulse | output | 1 | Divided feedback pulse, one prescaler cycle wide |
| ref_pulse | output | 1 | Divided reference pulse, one reference cycle wide |
| mod_ctl | output | 1 | Prescaler modulus request: 1 = divide by 17, 0 = divide by 16 |

## Verification
Each pulse is registered, so it becomes visible in the cycle after the edge on which its counter reaches zero. The bench samples every output on the falling edge of the clock that owns it. It measures each feedback interval in VCO cycles and each reference interval in reference cycles, counted from one sampled pulse to the next. A new select or ratio value shows up only in the second full interval after the change. The bench therefore waits for two pulse events before it checks a new setting, and it checks the interval just before that to confirm the old value still held. The first-pulse checks count clock edges seen with reset low and expect exactly P or R.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int SWALLOW_W = 4;
  localparam int MAIN_W    = 10;
  localparam int FB_W      = SWALLOW_W + MAIN_W;
  localparam int REF_W     = 11;
  localparam int FB_MIN    = 256;
  localparam int REF_MIN   = 2;
  localparam int MAIN_MIN  = FB_MIN >> SWALLOW_W;

  typedef struct packed {
    logic [MAIN_W-1:0]    main;
    logic [SWALLOW_W-1:0] swallow;
  } fb_ratio_t;
endpackage

// File: rtl/fdiv_bank_pick.sv
module fdiv_bank_pick #(
  parameter int W    = 11,
  parameter int MINV = 2
) (
  input  logic         sel,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic [W-1:0] word_o
);
  logic [W-1:0] picked;

  assign picked = sel ? word_a : word_b;

  generate
    if (MINV > 0) begin : g_clamp
      // out-of-range words are raised to the smallest legal ratio
      assign word_o = (picked < W'(MINV)) ? W'(MINV) : picked;
    end else begin : g_pass
      assign word_o = picked;
    end
  endgenerate
endmodule

// File: rtl/fdiv_swallow_ctr.sv
module fdiv_swallow_ctr
  import fdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  fb_ratio_t ld,
  output logic      pulse,
  output logic      mod_ctl
);
  logic [MAIN_W-1:0]    p_cnt;
  logic [SWALLOW_W-1:0] a_cnt;
  logic                 tc;

  assign tc      = (p_cnt == '0);
  assign mod_ctl = (a_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_cnt <= ld.main - MAIN_W'(1);
      a_cnt <= ld.swallow;
      pulse <= 1'b0;
    end else if (tc) begin
      p_cnt <= ld.main - MAIN_W'(1);
      a_cnt <= ld.swallow;
      pulse <= 1'b1;
    end else begin
      p_cnt <= p_cnt - MAIN_W'(1);
      if (a_cnt != '0) a_cnt <= a_cnt - SWALLOW_W'(1);
      pulse <= 1'b0;
    end
  end

  // R3: the feedback pulse never lasts two prescaler cycles
  a_r3_fb_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R2: swallow count only falls between reloads
  a_r2_swallow_falls: assert property (@(posedge clk) disable iff (rst)
    !tc |=> (a_cnt <= $past(a_cnt)));

  // R2: once divide-by-16 is requested it holds until the period ends
  a_r2_mod_stays_low: assert property (@(posedge clk) disable iff (rst)
    (!mod_ctl && !tc) |=> !mod_ctl);

  // R8: a reload never starts a period shorter than the minimum main count
  a_r8_main_floor: assert property (@(posedge clk) disable iff (rst)
    tc |=> (p_cnt >= MAIN_W'(MAIN_MIN - 1)));
endmodule

// File: rtl/fdiv_ref_ctr.sv
module fdiv_ref_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ld,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic         tc;

  assign tc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= ld - W'(1);
      pulse <= 1'b0;
    end else if (tc) begin
      cnt   <= ld - W'(1);
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt - W'(1);
      pulse <= 1'b0;
    end
  end

  // R4: the reference pulse is a single cycle
  a_r4_ref_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R9: a reload always leaves at least one further count
  a_r9_ref_floor: assert property (@(posedge clk) disable iff (rst)
    tc |=> (cnt >= W'(1)));
endmodule

// File: rtl/dual_mod_div_pair.sv
module dual_mod_div_pair
  import fdiv_pkg::*;
(
  input  logic             clk_pre,
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             bank_sel,
  input  logic [FB_W-1:0]  fb_word_a,
  input  logic [FB_W-1:0]  fb_word_b,
  input  logic [REF_W-1:0] ref_word_a,
  input  logic [REF_W-1:0] ref_word_b,
  output logic             fb_pulse,
  output logic             ref_pulse,
  output logic             mod_ctl
);
  logic [FB_W-1:0]  fb_word;
  logic [REF_W-1:0] ref_word;
  fb_ratio_t        fb_ld;

  fdiv_bank_pick #(.W(FB_W), .MINV(FB_MIN)) i_fb_pick (
    .sel    (bank_sel),
    .word_a (fb_word_a),
    .word_b (fb_word_b),
    .word_o (fb_word)
  );

  fdiv_bank_pick #(.W(REF_W), .MINV(REF_MIN)) i_ref_pick (
    .sel    (bank_sel),
    .word_a (ref_word_a),
    .word_b (ref_word_b),
    .word_o (ref_word)
  );

  assign fb_ld = fb_ratio_t'(fb_word);

  fdiv_swallow_ctr i_fb_ctr (
    .clk     (clk_pre),
    .rst     (rst),
    .ld      (fb_ld),
    .pulse   (fb_pulse),
    .mod_ctl (mod_ctl)
  );

  fdiv_ref_ctr #(.W(REF_W)) i_ref_ctr (
    .clk   (clk_ref),
    .rst   (rst),
    .ld    (ref_word),
    .pulse (ref_pulse)
  );

  // R7: no pulse leaves the block while reset is held
  a_r7_fb_quiet_in_reset: assert property (@(posedge clk_pre)
    $past(rst) |-> !fb_pulse);
  a_r7_ref_quiet_in_reset: assert property (@(posedge clk_ref)
    $past(rst) |-> !ref_pulse);
endmodule

// File: tb/test_dual_mod_div_pair.sv
`timescale 1ps/1ps
module test_dual_mod_div_pair;
  logic clk = 1'b0;
  logic vco = 1'b0;
  logic clk_pre = 1'b0;
  logic rst = 1'b1;
  logic bank_sel = 1'b1;
  logic [13:0] fb_a = 14'd260, fb_b = 14'd2000;
  logic [10:0] ref_a = 11'd13, ref_b = 11'd9;
  logic fb_pulse, ref_pulse, mod_ctl;

  int nchk = 0, nfail = 0;

  always #10000 clk = ~clk;
  initial begin
    #250;
    forever #500 vco = ~vco;
  end

  // behavioural 16/17 prescaler
  int pc = 0;
  always @(posedge vco) begin
    int lim;
    lim = mod_ctl ? 16 : 15;
    if (pc >= lim) pc = 0; else pc = pc + 1;
    clk_pre <= (pc < 8);
  end

  dual_mod_div_pair i_dual_mod_div_pair (
    .clk_pre(clk_pre), .clk_ref(clk), .rst(rst), .bank_sel(bank_sel),
    .fb_word_a(fb_a), .fb_word_b(fb_b), .ref_word_a(ref_a), .ref_word_b(ref_b),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .mod_ctl(mod_ctl)
  );

  longint vco_cnt = 0;
  always @(negedge vco) vco_cnt++;

  int pre_pos = 0, ref_pos = 0;
  always @(posedge clk_pre) if (rst) pre_pos = 0; else pre_pos++;
  always @(posedge clk)     if (rst) ref_pos = 0; else ref_pos++;

  event fb_ev, ref_ev;
  longint fb_last = 0, fb_iv = 0;
  int fb_mods = 0, mod_acc = 0, fb_first = 0, fb_wide = 0;
  bit fb_seen = 0, fb_prev = 0;
  always @(negedge clk_pre) begin
    if (rst) begin
      fb_seen = 0; fb_prev = 0; mod_acc = 0;
    end else begin
      if (fb_pulse) begin
        if (fb_prev) fb_wide++;
        if (!fb_seen) fb_first = pre_pos;
        fb_seen = 1;
        fb_iv = vco_cnt - fb_last;
        fb_last = vco_cnt;
        fb_mods = mod_acc;
        mod_acc = mod_ctl ? 1 : 0;
        -> fb_ev;
      end else if (mod_ctl) mod_acc++;
      fb_prev = fb_pulse;
    end
  end

  int ref_last = 0, ref_iv = 0, ref_first = 0, ref_wide = 0, ref_cyc = 0;
  bit ref_seen = 0, ref_prev = 0;
  always @(negedge clk) begin
    ref_cyc++;
    if (rst) begin
      ref_seen = 0; ref_prev = 0;
    end else begin
      if (ref_pulse) begin
        if (ref_prev) ref_wide++;
        if (!ref_seen) ref_first = ref_pos;
        ref_seen = 1;
        ref_iv = ref_cyc - ref_last;
        ref_last = ref_cyc;
        -> ref_ev;
      end
      ref_prev = ref_pulse;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(bit s, int fa, int fb, int ra, int rb);
    bank_sel = s; fb_a = 14'(fa); fb_b = 14'(fb); ref_a = 11'(ra); ref_b = 11'(rb);
  endtask

  task automatic wait_fb(int n);
    repeat (n) @(fb_ev);
  endtask

  task automatic wait_ref(int n);
    repeat (n) @(ref_ev);
  endtask

  task automatic t_reset;
    set_cfg(1, 260, 2000, 13, 9);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 fb_pulse in reset", fb_pulse, 0);
    chk("R7 ref_pulse in reset", ref_pulse, 0);
    chk("R2 mod_ctl loaded in reset (A=4)", mod_ctl, 1);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 first fb pulse edge", fb_first, 16);
    chk("R7 first ref pulse edge", ref_first, 13);
  endtask

  task automatic t_basic;
    wait_fb(2);
    chk("R1 fb interval 260", fb_iv, 260);
    chk("R2 swallow cycles 4", fb_mods, 4);
    wait_ref(2);
    chk("R4 ref interval 13", ref_iv, 13);
    chk("R3 fb pulse width", fb_wide, 0);
    chk("R4 ref pulse width", ref_wide, 0);
  endtask

  task automatic t_banks;
    set_cfg(1, 10519, 4269, 492, 492);
    wait_fb(2);
    chk("R5 set A fb 10519", fb_iv, 10519);
    chk("R2 swallow cycles 7", fb_mods, 7);
    bank_sel = 1'b0;
    wait_fb(2);
    chk("R5 set B fb 4269", fb_iv, 4269);
    chk("R2 swallow cycles 13", fb_mods, 13);
    wait_ref(2);
    chk("R4 ref interval 492", ref_iv, 492);
  endtask

  task automatic t_switch;
    set_cfg(1, 1000, 2000, 5, 9);
    wait_fb(2);
    @(fb_ev); bank_sel = 1'b0;
    @(fb_ev);
    chk("R6 fb period in progress keeps set A", fb_iv, 1000);
    chk("R6 swallow cycles 8", fb_mods, 8);
    @(fb_ev);
    chk("R6 fb set B after terminal count", fb_iv, 2000);
    chk("R2 A=0 never requests 17", fb_mods, 0);
    bank_sel = 1'b1;
    wait_fb(2);
    @(fb_ev); fb_a = 14'd300;
    @(fb_ev);
    chk("R6 fb ratio change deferred", fb_iv, 1000);
    @(fb_ev);
    chk("R6 fb new ratio 300", fb_iv, 300);
    chk("R2 swallow cycles 12", fb_mods, 12);
    wait_ref(2);
    chk("R5 set A ref 5", ref_iv, 5);
    @(ref_ev); bank_sel = 1'b0;
    @(ref_ev);
    chk("R6 ref period in progress keeps 5", ref_iv, 5);
    @(ref_ev);
    chk("R6 ref set B 9", ref_iv, 9);
  endtask

  task automatic t_clamp;
    set_cfg(1, 100, 0, 1, 0);
    wait_fb(2);
    chk("R8 fb word 100 runs as 256", fb_iv, 256);
    chk("R8 clamped A is 0", fb_mods, 0);
    wait_ref(2);
    chk("R9 ref word 1 runs as 2", ref_iv, 2);
    bank_sel = 1'b0;
    wait_fb(2);
    chk("R8 fb word 0 runs as 256", fb_iv, 256);
    wait_ref(2);
    chk("R9 ref word 0 runs as 2", ref_iv, 2);
  endtask

  task automatic t_max;
    set_cfg(1, 16383, 256, 2047, 2);
    wait_fb(2);
    chk("R10 fb max 16383", fb_iv, 16383);
    chk("R10 swallow cycles 15", fb_mods, 15);
    wait_ref(2);
    chk("R10 ref max 2047", ref_iv, 2047);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_banks();
        t_switch();
        t_clamp();
        t_max();
      end
      begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule